// File: doc/BRIEF.md
# Word Store Beat Splitter

This block sits between a narrow store port and a wide write path whose beats are a power-of-two number of bytes (16 by default, so 128 data bits). It takes one store at a time, either a single byte or a two-byte little-endian word. It turns that store into one or two beat writes. Each beat write has a beat index, a byte-enable mask with one bit per lane, and the data bytes placed in their lanes. Every lane that is not enabled carries zero.

A word whose two bytes land in the same beat leaves as one write with two lanes enabled. A word whose second byte falls in the next beat leaves as two writes. The write carrying the low-order data byte goes first. For stores flagged as stack traffic, the second byte's address wraps inside the 256-byte page of the first byte and does not carry into the next page. A stack word at a page's last byte therefore splits into the page's last beat followed by the page's first beat. Both sides use a valid/ready handshake. The store side is refused while any beat write is still pending.

Top module: `word_store_splitter`

## Requirements
- R1: After reset, wr_valid is 0 and st_ready is 1.
- R2: A byte store (st_word=0) gives one write. Its beat index is st_addr[15:4]. The enable mask has only bit st_addr[3:0] set. The data has st_data[7:0] at bits [8*lane+7 : 8*lane] and zero elsewhere.
- R3: A word store (st_word=1) whose second byte lies in the same beat gives one write. The low byte st_data[7:0] goes to the lane of the first address and the high byte st_data[15:8] goes to the lane of the second address. Both enable bits are set.
- R4: A non-stack word store (st_stack=0) takes its second byte address as st_addr+1, modulo 2^16. When lane 15 is used, this gives two writes. The first write is beat st_addr[15:4], enable bit 15, with the low byte. The second write is the next beat, enable bit 0, with the high byte.
- R5: For a stack word store (st_stack=1), the second address keeps st_addr[15:8] and increments st_addr[7:0] modulo 256. At offset xxFF this gives two writes: first beat xxF, then beat xx0 with enable bit 0.
- R6: A stack word store at lane 15 that is not at the end of its page splits exactly as in R4.
- R7: st_ready is 0 while wr_valid is 1, and a store offered then is not taken. An accepted store raises wr_valid on the next cycle.
- R8: While wr_valid is 1 and wr_ready is 0, the beat index, enable mask and data stay unchanged.
- R9: Every write enables one or two lanes, and every lane that is not enabled carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store request accepted this cycle |
| st_addr | input | ADDR_W (16) | Byte address of the store |
| st_data | input | 16 | Store data; bits [7:0] go to the lower address |
| st_word | input | 1 | 1 = two-byte store, 0 = single byte |
| st_stack | input | 1 | 1 = second byte wraps inside its page |
| wr_valid | output | 1 | Beat write present |
| wr_ready | input | 1 | Beat write taken |
| wr_beat | output | ADDR_W-4 (12) | Beat index |
| wr_be | output | BEAT_BYTES (16) | Byte-lane enables |
| wr_data | output | 8*BEAT_BYTES (128) | Lane-aligned data |

## Verification
Page wrap and beat splitting fall on the same store when a stack word targets the final byte of a page. In that case, one store must produce two writes in the wrap-specific order, with the second beat at the start of the same page. The sweep reaches this by running every lane with both store sizes and both stack settings over bases at the end of page one and the end of the address space. The writes expected from address arithmetic are compared beat by beat. Back-pressure stalls are placed between the two halves of a split, and a competing store is offered during them. This confirms that the held second half stays intact and that the competing store is never taken.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FIRST = 2'd1,
      WS_LAST  = 2'd2
   } ws_state_e;

endpackage

// File: rtl/wsplit_addr.sv
module wsplit_addr #(
   parameter int ADDR_W     = 16,
   parameter int LANE_W     = 4,
   parameter int PAGE_BITS  = 8,
   parameter bit STACK_WRAP = 1'b1
) (
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic              is_word,
   input  logic              is_stack,
   output logic [ADDR_W-1:0] hi_addr,
   output logic              split
);
   localparam logic [ADDR_W-1:0]    ONE_A = 1;
   localparam logic [PAGE_BITS-1:0] ONE_P = 1;

   generate
      if (STACK_WRAP) begin : g_wrap
         always_comb begin
            if (is_stack)
               hi_addr = {lo_addr[ADDR_W-1:PAGE_BITS], lo_addr[PAGE_BITS-1:0] + ONE_P};
            else
               hi_addr = lo_addr + ONE_A;
         end
      end else begin : g_linear
         always_comb hi_addr = lo_addr + ONE_A;
      end
   endgenerate

   always_comb split = is_word && (lo_addr[ADDR_W-1:LANE_W] != hi_addr[ADDR_W-1:LANE_W]);

endmodule

// File: rtl/wsplit_lanes.sv
module wsplit_lanes #(
   parameter int BEAT_BYTES = 16,
   parameter int LANE_W     = 4
) (
   input  logic [LANE_W-1:0]         lane_a,
   input  logic [7:0]                byte_a,
   input  logic                      en_a,
   input  logic [LANE_W-1:0]         lane_b,
   input  logic [7:0]                byte_b,
   input  logic                      en_b,
   output logic [BEAT_BYTES-1:0]     be,
   output logic [BEAT_BYTES*8-1:0]   data
);
   generate
      for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
         logic hit_a, hit_b;
         always_comb begin
            hit_a = en_a && (lane_a == LANE_W'(i));
            hit_b = en_b && (lane_b == LANE_W'(i));
            be[i] = hit_a || hit_b;
            if (hit_b)
               data[i*8 +: 8] = byte_b;
            else if (hit_a)
               data[i*8 +: 8] = byte_a;
            else
               data[i*8 +: 8] = 8'h00;
         end
      end
   endgenerate

endmodule

// File: rtl/word_store_splitter.sv
module word_store_splitter
   import wsplit_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BEAT_BYTES = 16,
   parameter int PAGE_BITS  = 8,
   parameter bit STACK_WRAP = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        st_valid,
   output logic                        st_ready,
   input  logic [ADDR_W-1:0]           st_addr,
   input  logic [15:0]                 st_data,
   input  logic                        st_word,
   input  logic                        st_stack,
   output logic                        wr_valid,
   input  logic                        wr_ready,
   output logic [ADDR_W-$clog2(BEAT_BYTES)-1:0] wr_beat,
   output logic [BEAT_BYTES-1:0]       wr_be,
   output logic [BEAT_BYTES*8-1:0]     wr_data
);
   localparam int LANE_W = $clog2(BEAT_BYTES);
   localparam int DATA_W = BEAT_BYTES * 8;
   localparam int BEAT_W = ADDR_W - LANE_W;

   generate
      if (BEAT_BYTES < 2 || (1 << LANE_W) != BEAT_BYTES) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two of at least 2");
      end
      if (PAGE_BITS <= LANE_W || PAGE_BITS > ADDR_W) begin : g_bad_page
         $error("PAGE_BITS must exceed the lane index width and fit the address");
      end
   endgenerate

   logic [ADDR_W-1:0]     hi_addr;
   logic                  split;
   logic [BEAT_BYTES-1:0] be_first, be_second;
   logic [DATA_W-1:0]     data_first, data_second;

   wsplit_addr #(
      .ADDR_W(ADDR_W), .LANE_W(LANE_W), .PAGE_BITS(PAGE_BITS), .STACK_WRAP(STACK_WRAP)
   ) u_addr (
      .lo_addr(st_addr), .is_word(st_word), .is_stack(st_stack),
      .hi_addr(hi_addr), .split(split)
   );

   wsplit_lanes #(.BEAT_BYTES(BEAT_BYTES), .LANE_W(LANE_W)) u_first (
      .lane_a(st_addr[LANE_W-1:0]), .byte_a(st_data[7:0]), .en_a(1'b1),
      .lane_b(hi_addr[LANE_W-1:0]), .byte_b(st_data[15:8]), .en_b(st_word && !split),
      .be(be_first), .data(data_first)
   );

   wsplit_lanes #(.BEAT_BYTES(BEAT_BYTES), .LANE_W(LANE_W)) u_second (
      .lane_a(hi_addr[LANE_W-1:0]), .byte_a(st_data[15:8]), .en_a(1'b1),
      .lane_b('0), .byte_b(8'h00), .en_b(1'b0),
      .be(be_second), .data(data_second)
   );

   ws_state_e             state;
   logic [BEAT_W-1:0]     nxt_beat;
   logic [BEAT_BYTES-1:0] nxt_be;
   logic [DATA_W-1:0]     nxt_data;

   assign st_ready = (state == WS_IDLE);
   assign wr_valid = (state != WS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= WS_IDLE;
         wr_beat  <= '0;
         wr_be    <= '0;
         wr_data  <= '0;
         nxt_beat <= '0;
         nxt_be   <= '0;
         nxt_data <= '0;
      end else begin
         case (state)
            WS_IDLE: begin
               if (st_valid) begin
                  wr_beat  <= st_addr[ADDR_W-1:LANE_W];
                  wr_be    <= be_first;
                  wr_data  <= data_first;
                  nxt_beat <= hi_addr[ADDR_W-1:LANE_W];
                  nxt_be   <= be_second;
                  nxt_data <= data_second;
                  state    <= split ? WS_FIRST : WS_LAST;
               end
            end
            WS_FIRST: begin
               if (wr_ready) begin
                  wr_beat <= nxt_beat;
                  wr_be   <= nxt_be;
                  wr_data <= nxt_data;
                  state   <= WS_LAST;
               end
            end
            WS_LAST: begin
               if (wr_ready) state <= WS_IDLE;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wsplit_chk.sv
module wsplit_chk #(
   parameter int ADDR_W     = 16,
   parameter int BEAT_BYTES = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        st_valid,
   input logic                        st_ready,
   input logic                        st_word,
   input logic                        wr_valid,
   input logic                        wr_ready,
   input logic [ADDR_W-$clog2(BEAT_BYTES)-1:0] wr_beat,
   input logic [BEAT_BYTES-1:0]       wr_be,
   input logic [BEAT_BYTES*8-1:0]     wr_data
);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_beat) && $stable(wr_be) && $stable(wr_data));

   a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !st_ready);

   a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_ready |=> wr_valid);

   a_r9_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2));

   a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_ready && !st_word |=> $countones(wr_be) == 1);

endmodule

bind word_store_splitter wsplit_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_beat(wr_beat), .wr_be(wr_be), .wr_data(wr_data)
);

// File: tb/tb_word_store_splitter.sv
module tb_word_store_splitter;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         st_valid, st_ready, st_word, st_stack;
   logic [15:0]  st_addr, st_data;
   logic         wr_valid, wr_ready;
   logic [11:0]  wr_beat;
   logic [15:0]  wr_be;
   logic [127:0] wr_data;
   int           checks = 0;
   int           errors = 0;
   int           seq = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   word_store_splitter dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_word(st_word), .st_stack(st_stack),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_beat(wr_beat), .wr_be(wr_be),
      .wr_data(wr_data)
   );

   task automatic chk(input string tag, input bit ok, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [15:0] addr, input logic word, input logic stack);
      logic [15:0]  lo, hi, d;
      logic [11:0]  e_beat [2];
      logic [15:0]  e_be [2];
      logic [127:0] e_dat [2];
      int           n;
      string        tag;
      lo = addr;
      hi = stack ? {addr[15:8], addr[7:0] + 8'd1} : addr + 16'd1;
      d  = {8'h5A ^ addr[7:0], 8'hC3 ^ addr[15:8]};
      n  = (word && hi[15:4] != lo[15:4]) ? 2 : 1;
      if (!word)          tag = "R2";
      else if (n == 1)    tag = "R3";
      else if (!stack)    tag = "R4";
      else if (hi < lo)   tag = "R5";
      else                tag = "R6";
      e_beat[0] = lo[15:4];
      e_be[0]   = 16'd1 << lo[3:0];
      e_dat[0]  = '0;
      e_dat[0][lo[3:0]*8 +: 8] = d[7:0];
      if (word && n == 1) begin
         e_be[0] = e_be[0] | (16'd1 << hi[3:0]);
         e_dat[0][hi[3:0]*8 +: 8] = d[15:8];
      end
      e_beat[1] = hi[15:4];
      e_be[1]   = 16'd1 << hi[3:0];
      e_dat[1]  = '0;
      e_dat[1][hi[3:0]*8 +: 8] = d[15:8];

      st_valid = 1'b1; st_addr = addr; st_data = d; st_word = word; st_stack = stack;
      @(negedge clk);
      st_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         int stalls;
         stalls = seq % 3;
         seq++;
         for (int s = 0; s < stalls; s++) begin
            wr_ready = 1'b0;
            st_valid = 1'b1; st_addr = ~addr; st_word = 1'b0; st_stack = 1'b0;
            // R7: refused while a write is pending
            chk("R7", st_ready == 1'b0 && wr_valid == 1'b1, {st_ready, wr_valid}, 2'b01);
            // R8: payload held under back-pressure
            chk("R8", {wr_beat, wr_be, wr_data} == {e_beat[k], e_be[k], e_dat[k]},
                {wr_beat, wr_be, wr_data}, {e_beat[k], e_be[k], e_dat[k]});
            @(negedge clk);
         end
         st_valid = 1'b0;
         wr_ready = 1'b1;
         chk(tag, wr_valid == 1'b1 && {wr_beat, wr_be, wr_data} == {e_beat[k], e_be[k], e_dat[k]},
             {wr_valid, wr_beat, wr_be, wr_data}, {1'b1, e_beat[k], e_be[k], e_dat[k]});
         // R9: no data outside enabled lanes, one or two lanes
         chk("R9", $countones(wr_be) inside {1, 2}, wr_be, e_be[k]);
         @(negedge clk);
         wr_ready = 1'b0;
      end
      // R7: the competing store was not taken; block idle again
      chk("R7", wr_valid == 1'b0 && st_ready == 1'b1, {wr_valid, st_ready}, 2'b01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] bases [4];
      bases[0] = 16'h0100; bases[1] = 16'h01F0; bases[2] = 16'h3450; bases[3] = 16'hFFF0;
      rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
      st_word = 1'b0; st_stack = 1'b0; wr_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", wr_valid == 1'b0 && st_ready == 1'b1, {wr_valid, st_ready}, 2'b01);
      for (int b = 0; b < 4; b++)
         for (int ln = 0; ln < 16; ln++)
            for (int w = 0; w < 2; w++)
               for (int s = 0; s < 2; s++)
                  run(bases[b] | 16'(ln), w[0], s[0]);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule